// File: doc/BRIEF.md
# Wavefront Issue Gate

This block sits between a wavefront's instruction buffer and the pipeline schedulers of a compute unit. Each cycle it answers whether the oldest buffered instruction of one wavefront may go to the pipeline class a scheduler is asking about: vector ALU, global memory, shared (local) memory, private memory or flat memory. It looks at the wavefront's run state, the instruction class, the memory operation kind, operand and register-port readiness, request-queue space, and its own record of memory traffic still in flight.

That record is four request channels: global read, global write, local read and local write. Each channel counts requests waiting in the issue pipe and requests outstanding at memory. Reads and writes of one space are ordered against each other through these counts. When the scheduler fires an instruction that is ready, the block does three things. It starts the issue-slot hold timer for the unit used. For memory operations it also starts the register-to-memory bus timer, whose length depends on the operation kind. Finally, it counts the new request on its channels.

Top module: `wfg_issue_gate`

## Requirements
- R1: `ready` is 0 whenever `wf_state` is not running (encoding 0 stopped, 1 running, 2 returning, 3 treated as stopped) or `buf_empty` is 1.
- R2: `ready` is 0 unless `pipe_sel` matches the instruction class. Class codes on `inst_kind` are 0 ALU, 1 barrier, 2 return, 3 global, 4 shared, 5 private, 6 flat; 7 is never ready. Pipe codes on `pipe_sel` are 0 ALU, 1 global, 2 shared, 3 private, 4 flat. Classes 0 to 2 use pipe 0, and class k from 3 to 6 uses pipe k-2.
- R3: An ALU instruction is ready when the ALU issue slot is free and both `opnd_ready` and `port_ready` are 1. Any issue on the ALU slot (ALU, barrier, return) keeps that slot busy for `ISSUE_PERIOD` cycles after the issuing edge.
- R4: A barrier or return is ready only when the ALU slot is free and all four channels hold no in-pipe and no outstanding request. Operand and port flags have no effect on it.
- R5: `mem_op` is 0 read, 1 write, 2 atomic, 3 treated as atomic. A global or shared read or atomic is blocked while its space's write channel is non-empty. A global or shared write or atomic is blocked while its space's read channel is non-empty. A global request also needs the global slot, the global bus, `gfifo_space` and both operand flags free or set; a shared request needs the shared slot, the local bus, `lfifo_space` and both flags.
- R6: A private request follows the global rules: it is ordered against, and counted on, the global channels, and it uses the global slot and the global bus.
- R7: A flat request needs both slots, both buses, both `gfifo_space` and `lfifo_space`, and both operand flags. It is not ordered by the channels. On issue it is counted on the global channels, and it starts the global slot and the global bus timers.
- R8: A memory issue puts the bus length on `gbus_len` (global, private, flat) or `lbus_len` (shared) for that cycle: `RD_BUS_TICKS` (4) for a read, `WR_BUS_TICKS` (8) for a write or atomic. The bus then stays busy for that many cycles.
- R9: An issued atomic adds one to both the read and the write channel of its space. A read or a write adds one to its own channel only.
- R10: A `send_pulse` bit moves one request of its channel from in-pipe to outstanding, and a `done_pulse` bit retires one outstanding request. An increment and a send in the same cycle leave the in-pipe count unchanged. Channel bit order is 0 global read, 1 global write, 2 local read, 3 local write.
- R11: An issue happens only when `issue_req` and `ready` are both 1. Otherwise `slot_start`, `gbus_len` and `lbus_len` are all 0. `slot_start` bits are 0 ALU slot, 1 global slot, 2 shared slot.
- R12: After reset all slots and buses are free and all channels are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wf_state | input | 2 | Wavefront run state |
| buf_empty | input | 1 | Instruction buffer is empty |
| inst_kind | input | 3 | Class of the oldest instruction |
| mem_op | input | 2 | Memory operation kind |
| pipe_sel | input | 3 | Pipeline class being asked about |
| opnd_ready | input | 1 | Source/destination operands free of hazards |
| port_ready | input | 1 | Register file ports can be scheduled |
| gfifo_space | input | 1 | Global request queue can accept |
| lfifo_space | input | 1 | Local request queue can accept |
| issue_req | input | 1 | Scheduler fires the instruction if ready |
| send_pulse | input | 4 | Per-channel in-pipe to outstanding move |
| done_pulse | input | 4 | Per-channel outstanding completion |
| ready | output | 1 | Instruction may issue to `pipe_sel` |
| slot_start | output | 3 | Issue-slot timers started this cycle |
| gbus_len | output | clog2(max(RD,WR)+1) | Global bus timer preset, 0 when none |
| lbus_len | output | clog2(max(RD,WR)+1) | Local bus timer preset, 0 when none |

## Verification
The bench targets the exact edges of every hold window. A timer that is off by one would raise `ready` a cycle early or late after an ALU issue or after a four- or eight-cycle bus hold. It also targets ordering in both directions, including atomics that occupy both channels. A design that counts an atomic on one channel only would let a following read or write slip past it. Other cases covered are private requests landing on the global channels, flat requests waiting on either bus, and a request issued in the same cycle that a send drains its channel. Each of these mistakes shows up either as a wrong `ready` in a later cycle or as a barrier that issues while memory traffic is still live.

// File: rtl/wfg_pkg.sv
package wfg_pkg;

  typedef enum logic [2:0] {
    K_ALU = 3'd0, K_BAR = 3'd1, K_RET = 3'd2, K_GLB = 3'd3,
    K_SHR = 3'd4, K_PRV = 3'd5, K_FLT = 3'd6, K_BAD = 3'd7
  } kind_e;

  typedef enum logic [2:0] {
    P_ALU = 3'd0, P_GLB = 3'd1, P_SHR = 3'd2, P_PRV = 3'd3, P_FLT = 3'd4
  } pipe_e;

  localparam int CH_GRD = 0;
  localparam int CH_GWR = 1;
  localparam int CH_LRD = 2;
  localparam int CH_LWR = 3;

  // pipeline class a given instruction class belongs to
  function automatic logic [2:0] pipe_of(kind_e k);
    case (k)
      K_ALU, K_BAR, K_RET: return P_ALU;
      K_GLB:               return P_GLB;
      K_SHR:               return P_SHR;
      K_PRV:               return P_PRV;
      K_FLT:               return P_FLT;
      default:             return 3'd7;
    endcase
  endfunction

  function automatic logic op_reads(logic [1:0] op);
    return op != 2'd1;
  endfunction

  function automatic logic op_writes(logic [1:0] op);
    return op != 2'd0;
  endfunction

  function automatic int bus_ticks(logic [1:0] op, int rd_t, int wr_t);
    return (op == 2'd0) ? rd_t : wr_t;
  endfunction

  function automatic int len_w(int a, int b);
    int m;
    m = (a > b) ? a : b;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/wfg_busy_timer.sv
module wfg_busy_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         free
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= len;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign free = (cnt == '0);
endmodule

// File: rtl/wfg_req_chan.sv
module wfg_req_chan #(
  parameter int CW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic send,
  input  logic done,
  output logic idle,
  output logic full
);
  logic [CW-1:0] in_pipe;
  logic [CW-1:0] in_flight;
  logic          send_ok;
  logic          done_ok;

  assign send_ok = send & ((in_pipe != '0) | inc);
  assign done_ok = done & ((in_flight != '0) | send_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pipe   <= '0;
      in_flight <= '0;
    end else begin
      in_pipe   <= in_pipe + CW'(inc) - CW'(send_ok);
      in_flight <= in_flight + CW'(send_ok) - CW'(done_ok);
    end
  end

  assign idle = (in_pipe == '0) && (in_flight == '0);
  assign full = &in_pipe;
endmodule

// File: rtl/wfg_issue_gate.sv
module wfg_issue_gate import wfg_pkg::*; #(
  parameter int ISSUE_PERIOD = 4,
  parameter int RD_BUS_TICKS = 4,
  parameter int WR_BUS_TICKS = 8,
  parameter int CNT_W        = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wf_state,
  input  logic       buf_empty,
  input  logic [2:0] inst_kind,
  input  logic [1:0] mem_op,
  input  logic [2:0] pipe_sel,
  input  logic       opnd_ready,
  input  logic       port_ready,
  input  logic       gfifo_space,
  input  logic       lfifo_space,
  input  logic       issue_req,
  input  logic [3:0] send_pulse,
  input  logic [3:0] done_pulse,
  output logic       ready,
  output logic [2:0] slot_start,
  output logic [wfg_pkg::len_w(RD_BUS_TICKS, WR_BUS_TICKS)-1:0] gbus_len,
  output logic [wfg_pkg::len_w(RD_BUS_TICKS, WR_BUS_TICKS)-1:0] lbus_len
);
  localparam int SW    = $clog2(ISSUE_PERIOD + 1);
  localparam int BW    = len_w(RD_BUS_TICKS, WR_BUS_TICKS);
  localparam int NSLOT = 3;
  localparam int NBUS  = 2;
  localparam int NCH   = 4;

  kind_e            kind;
  logic             running, pipe_match, ops_ok, is_local, is_mem;
  logic             rd_busy, wr_busy, order_ok, cls_ok, fire, pend_any;
  logic [NSLOT-1:0] slot_free;
  logic [NBUS-1:0]  bus_free;
  logic [NBUS-1:0]  bus_load;
  logic [BW-1:0]    bus_len_arr [NBUS];
  logic [NCH-1:0]   ch_idle, ch_full, ch_inc;
  logic [BW-1:0]    blen;

  assign kind       = kind_e'(inst_kind);
  assign running    = (wf_state == 2'd1) && !buf_empty;
  assign pipe_match = (pipe_of(kind) == pipe_sel);
  assign ops_ok     = opnd_ready & port_ready;
  assign is_local   = (kind == K_SHR);
  assign is_mem     = (kind == K_GLB) || (kind == K_SHR) ||
                      (kind == K_PRV) || (kind == K_FLT);
  assign pend_any   = ~&ch_idle;

  // ordering: same-space traffic of the opposite direction
  assign rd_busy  = is_local ? !ch_idle[CH_LRD] : !ch_idle[CH_GRD];
  assign wr_busy  = is_local ? !ch_idle[CH_LWR] : !ch_idle[CH_GWR];
  assign order_ok = !(op_reads(mem_op) && wr_busy) &&
                    !(op_writes(mem_op) && rd_busy);

  always_comb begin
    case (kind)
      K_ALU:        cls_ok = slot_free[0] & ops_ok;
      K_BAR, K_RET: cls_ok = slot_free[0] & !pend_any;
      K_GLB, K_PRV: cls_ok = order_ok & slot_free[1] & bus_free[0] &
                             gfifo_space & ops_ok;
      K_SHR:        cls_ok = order_ok & slot_free[2] & bus_free[1] &
                             lfifo_space & ops_ok;
      K_FLT:        cls_ok = slot_free[1] & slot_free[2] & (&bus_free) &
                             gfifo_space & lfifo_space & ops_ok;
      default:      cls_ok = 1'b0;
    endcase
  end

  assign ready = running & pipe_match & cls_ok;
  assign fire  = issue_req & ready;

  assign slot_start[0] = fire & !is_mem;
  assign slot_start[1] = fire & is_mem & !is_local;
  assign slot_start[2] = fire & is_local;

  assign blen     = BW'(bus_ticks(mem_op, RD_BUS_TICKS, WR_BUS_TICKS));
  assign gbus_len = slot_start[1] ? blen : '0;
  assign lbus_len = slot_start[2] ? blen : '0;

  assign ch_inc[CH_GRD] = slot_start[1] & op_reads(mem_op);
  assign ch_inc[CH_GWR] = slot_start[1] & op_writes(mem_op);
  assign ch_inc[CH_LRD] = slot_start[2] & op_reads(mem_op);
  assign ch_inc[CH_LWR] = slot_start[2] & op_writes(mem_op);

  assign bus_len_arr[0] = gbus_len;
  assign bus_len_arr[1] = lbus_len;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    wfg_busy_timer #(.W(SW)) u_slot (
      .clk(clk), .rst_n(rst_n), .load(slot_start[s]),
      .len(SW'(ISSUE_PERIOD)), .free(slot_free[s])
    );
  end

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    assign bus_load[b] = (bus_len_arr[b] != '0);
    wfg_busy_timer #(.W(BW)) u_bus (
      .clk(clk), .rst_n(rst_n), .load(bus_load[b]),
      .len(bus_len_arr[b]), .free(bus_free[b])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    wfg_req_chan #(.CW(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .inc(ch_inc[c]),
      .send(send_pulse[c]), .done(done_pulse[c]),
      .idle(ch_idle[c]), .full(ch_full[c])
    );
  end
endmodule

// File: rtl/wfg_issue_gate_chk.sv
module wfg_issue_gate_chk #(
  parameter int RD_BUS_TICKS = 4,
  parameter int WR_BUS_TICKS = 8,
  parameter int BW           = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    wf_state,
  input logic          buf_empty,
  input logic [2:0]    inst_kind,
  input logic [1:0]    mem_op,
  input logic [2:0]    pipe_sel,
  input logic          ready,
  input logic [2:0]    slot_start,
  input logic [BW-1:0] gbus_len,
  input logic [BW-1:0] lbus_len,
  input logic          alu_free,
  input logic          gb_free,
  input logic          lb_free,
  input logic [3:0]    ch_idle,
  input logic [3:0]    ch_full,
  input logic [3:0]    ch_inc
);
  logic [2:0] want_pipe;
  assign want_pipe = (inst_kind < 3'd3) ? 3'd0 : (inst_kind - 3'd2);

  AST_IDLE_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wf_state != 2'd1 || buf_empty) |-> !ready); // R1
  AST_PIPE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (pipe_sel == want_pipe)); // R2
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start[0] |=> !alu_free); // R3
  AST_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && (inst_kind == 3'd1 || inst_kind == 3'd2)) |-> (ch_idle == 4'hF)); // R4
  AST_ORDER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && (inst_kind == 3'd3 || inst_kind == 3'd5) && mem_op != 2'd1) |-> ch_idle[1]); // R5
  AST_FLAT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && inst_kind == 3'd6) |-> (gb_free && lb_free)); // R7
  AST_BUS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (gbus_len != '0) |-> (gbus_len == BW'(RD_BUS_TICKS) || gbus_len == BW'(WR_BUS_TICKS))); // R8
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_inc != 4'h0) |-> ((ch_inc & ch_full) == 4'h0)); // R9
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_idle[0] && !ch_inc[0]) |=> ch_idle[0]); // R10
  AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (slot_start == 3'b000 && gbus_len == '0 && lbus_len == '0)); // R11
endmodule

bind wfg_issue_gate wfg_issue_gate_chk #(
  .RD_BUS_TICKS(RD_BUS_TICKS), .WR_BUS_TICKS(WR_BUS_TICKS), .BW(BW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wf_state(wf_state), .buf_empty(buf_empty),
  .inst_kind(inst_kind), .mem_op(mem_op), .pipe_sel(pipe_sel),
  .ready(ready), .slot_start(slot_start), .gbus_len(gbus_len),
  .lbus_len(lbus_len), .alu_free(slot_free[0]), .gb_free(bus_free[0]),
  .lb_free(bus_free[1]), .ch_idle(ch_idle), .ch_full(ch_full),
  .ch_inc(ch_inc)
);

// File: tb/wfg_issue_gate_bench.sv
module wfg_issue_gate_bench;
  localparam int IP = 4;
  localparam int RB = 4;
  localparam int WB = 8;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] wf_state = 0;
  logic       buf_empty = 1;
  logic [2:0] inst_kind = 0;
  logic [1:0] mem_op = 0;
  logic [2:0] pipe_sel = 0;
  logic       opnd_ready = 0, port_ready = 0, gfifo_space = 0, lfifo_space = 0;
  logic       issue_req = 0;
  logic [3:0] send_pulse = 0, done_pulse = 0;
  logic       ready;
  logic [2:0] slot_start;
  logic [3:0] gbus_len, lbus_len;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int m_slot [3];
  int m_bus [2];
  int m_ip [4];
  int m_os [4];
  logic [31:0] rng = 32'h1234_5678;

  always #2 clk = ~clk;

  wfg_issue_gate #(.ISSUE_PERIOD(IP), .RD_BUS_TICKS(RB), .WR_BUS_TICKS(WB), .CNT_W(4)) u_wfg_issue_gate (
    .clk(clk), .rst_n(rst_n), .wf_state(wf_state), .buf_empty(buf_empty),
    .inst_kind(inst_kind), .mem_op(mem_op), .pipe_sel(pipe_sel),
    .opnd_ready(opnd_ready), .port_ready(port_ready), .gfifo_space(gfifo_space),
    .lfifo_space(lfifo_space), .issue_req(issue_req), .send_pulse(send_pulse),
    .done_pulse(done_pulse), .ready(ready), .slot_start(slot_start),
    .gbus_len(gbus_len), .lbus_len(lbus_len));

  function automatic int kpipe(int k);
    if (k < 3) return 0;
    if (k < 7) return k - 2;
    return 99;
  endfunction

  function automatic bit exp_ready(int st, int em, int k, int p, int op, int fl);
    bit ops, rd, wr, alu, gs, ls, gb, lb;
    int gr, gw, lr, lw;
    ops = fl[0] && fl[1];
    if (st != 1 || em != 0) return 0;
    if (kpipe(k) != p) return 0;
    rd = (op != 1); wr = (op != 0);
    gr = m_ip[0] + m_os[0]; gw = m_ip[1] + m_os[1];
    lr = m_ip[2] + m_os[2]; lw = m_ip[3] + m_os[3];
    alu = m_slot[0] == 0; gs = m_slot[1] == 0; ls = m_slot[2] == 0;
    gb = m_bus[0] == 0; lb = m_bus[1] == 0;
    case (k)
      0: return alu && ops;
      1, 2: return alu && (gr + gw + lr + lw == 0);
      3, 5: return !(rd && gw > 0) && !(wr && gr > 0) && gs && gb && fl[2] && ops;
      4: return !(rd && lw > 0) && !(wr && lr > 0) && ls && lb && fl[3] && ops;
      6: return gs && ls && gb && lb && fl[2] && fl[3] && ops;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int st, int em, int k, int p);
    if (st != 1 || em != 0) return "R1";
    if (kpipe(k) != p) return "R2";
    if (k == 0) return "R3";
    if (k < 3) return "R4";
    if (k == 5) return "R6";
    if (k == 6) return "R7";
    return "R5";
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic logic [31:0] nxt(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  // one cycle: called at negedge, returns at the next negedge
  task automatic cyc(int st, int em, int k, int p, int op, int fl, bit iss,
                     logic [3:0] snd, logic [3:0] dn, string tag);
    bit er, fire;
    logic [2:0] es;
    int eg, el, base;
    logic [3:0] sm, dm, inc;
    string t;
    for (int c = 0; c < 4; c++) begin
      sm[c] = snd[c] && (m_ip[c] > 0);
      dm[c] = dn[c] && (m_os[c] > 0);
    end
    wf_state = 2'(st); buf_empty = em[0]; inst_kind = 3'(k); pipe_sel = 3'(p);
    mem_op = 2'(op); opnd_ready = fl[0]; port_ready = fl[1];
    gfifo_space = fl[2]; lfifo_space = fl[3]; issue_req = iss;
    send_pulse = sm; done_pulse = dm;
    #1;
    er = exp_ready(st, em, k, p, op, fl);
    fire = iss && er;
    es = 3'b000; eg = 0; el = 0; inc = 4'b0;
    if (fire) begin
      if (k < 3) es[0] = 1;
      else if (k == 4) es[2] = 1;
      else es[1] = 1;
      if (k >= 3) begin
        if (k == 4) el = (op == 0) ? RB : WB; else eg = (op == 0) ? RB : WB;
        base = (k == 4) ? 2 : 0;
        inc[base] = (op != 1); inc[base + 1] = (op != 0);
      end
    end
    t = (tag != "") ? tag : tag_of(st, em, k, p);
    check(ready == er, t, "ready", int'(ready), int'(er));
    check(slot_start == es, (tag != "") ? tag : "R11", "slot_start", int'(slot_start), int'(es));
    check(int'(gbus_len) == eg, (tag != "") ? tag : "R8", "gbus_len", int'(gbus_len), eg);
    check(int'(lbus_len) == el, (tag != "") ? tag : "R8", "lbus_len", int'(lbus_len), el);
    @(posedge clk);
    for (int s = 0; s < 3; s++)
      if (es[s]) m_slot[s] = IP; else if (m_slot[s] > 0) m_slot[s]--;
    if (eg != 0) m_bus[0] = eg; else if (m_bus[0] > 0) m_bus[0]--;
    if (el != 0) m_bus[1] = el; else if (m_bus[1] > 0) m_bus[1]--;
    for (int c = 0; c < 4; c++) begin
      m_ip[c] = m_ip[c] + int'(inc[c]) - int'(sm[c]);
      m_os[c] = m_os[c] + int'(sm[c]) - int'(dm[c]);
    end
    @(negedge clk);
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 40; i++) begin
      logic [3:0] s, d;
      for (int c = 0; c < 4; c++) begin
        s[c] = m_ip[c] > 0; d[c] = m_os[c] > 0;
      end
      cyc(1, 0, 1, 0, 0, 15, 0, s, d, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) m_slot[i] = 0;
    for (int i = 0; i < 2; i++) m_bus[i] = 0;
    for (int i = 0; i < 4; i++) begin m_ip[i] = 0; m_os[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R12: reset leaves everything free and empty
    cyc(1, 0, 1, 0, 0, 0, 0, 0, 0, "R12");
    cyc(1, 0, 3, 1, 1, 15, 0, 0, 0, "R12");
    cyc(1, 0, 4, 2, 2, 15, 0, 0, 0, "R12");

    // R1/R2 plus class rules: sweep with idle state
    for (int st = 0; st < 4; st++)
      for (int em = 0; em < 2; em++)
        for (int k = 0; k < 8; k++)
          for (int p = 0; p < 8; p++)
            for (int op = 0; op < 4; op++)
              for (int fl = 0; fl < 16; fl++) begin
                bit er;
                wf_state = 2'(st); buf_empty = em[0]; inst_kind = 3'(k);
                pipe_sel = 3'(p); mem_op = 2'(op); opnd_ready = fl[0];
                port_ready = fl[1]; gfifo_space = fl[2]; lfifo_space = fl[3];
                issue_req = 0; send_pulse = 0; done_pulse = 0;
                #1;
                er = exp_ready(st, em, k, p, op, fl);
                check(ready == er, tag_of(st, em, k, p), "sweep ready", int'(ready), int'(er));
              end
    @(negedge clk);

    // R3: ALU slot hold window
    cyc(1, 0, 0, 0, 0, 15, 1, 0, 0, "R3");
    for (int i = 0; i < IP + 1; i++) cyc(1, 0, 0, 0, 0, 15, 0, 0, 0, "R3");
    cyc(1, 0, 0, 0, 0, 1, 0, 0, 0, "R3");

    // R8: write holds global bus 8 cycles, read 4
    cyc(1, 0, 3, 1, 1, 15, 1, 0, 0, "R8");
    for (int i = 0; i < WB + 1; i++) cyc(1, 0, 3, 1, 1, 15, 0, 0, 0, "R8");
    // R4: barrier waits for drain, ignores operand flags
    cyc(1, 0, 1, 0, 0, 0, 0, 0, 0, "R4");
    drain("R10");
    cyc(1, 0, 2, 0, 0, 0, 0, 0, 0, "R4");
    cyc(1, 0, 4, 2, 0, 15, 1, 0, 0, "R8");
    for (int i = 0; i < RB + 1; i++) cyc(1, 0, 4, 2, 0, 15, 0, 0, 0, "R8");
    drain("R10");

    // R9: atomic blocks both directions
    cyc(1, 0, 3, 1, 2, 15, 1, 0, 0, "R9");
    for (int i = 0; i < WB + 1; i++) cyc(1, 0, 3, 1, i % 2, 15, 0, 0, 0, "R9");
    drain("R10");
    cyc(1, 0, 3, 1, 0, 15, 1, 0, 0, "R9");
    for (int i = 0; i < RB + 1; i++) cyc(1, 0, 3, 1, 0, 15, 0, 0, 0, "R9");
    cyc(1, 0, 3, 1, 1, 15, 0, 0, 0, "R9");
    drain("R10");

    // R6: private read lands on global channels
    cyc(1, 0, 5, 3, 0, 15, 1, 0, 0, "R6");
    for (int i = 0; i < RB + 1; i++) cyc(1, 0, 3, 1, 1, 15, 0, 0, 0, "R6");
    cyc(1, 0, 4, 2, 1, 15, 0, 0, 0, "R6");
    drain("R10");

    // R10: issue and send in the same cycle
    cyc(1, 0, 4, 2, 0, 15, 1, 0, 0, "R10");
    for (int i = 0; i < WB; i++) cyc(1, 0, 4, 2, 0, 15, 0, 0, 0, "R10");
    cyc(1, 0, 4, 2, 0, 15, 1, 4'b0100, 0, "R10");
    for (int i = 0; i < WB; i++) cyc(1, 0, 4, 2, 1, 15, 0, 0, 4'b0100, "R10");
    cyc(1, 0, 4, 2, 1, 15, 0, 4'b0100, 4'b0100, "R10");
    cyc(1, 0, 4, 2, 1, 15, 0, 0, 4'b0100, "R10");
    cyc(1, 0, 4, 2, 1, 15, 0, 0, 0, "R10");
    drain("R10");

    // R7: flat needs both buses and both queues
    cyc(1, 0, 6, 4, 0, 7, 0, 0, 0, "R7");
    cyc(1, 0, 4, 2, 0, 15, 1, 0, 0, "R7");
    for (int i = 0; i < RB + 1; i++) cyc(1, 0, 6, 4, 0, 15, 0, 0, 0, "R7");
    cyc(1, 0, 6, 4, 1, 15, 1, 0, 0, "R7");
    drain("R10");

    // R11 and mixed traffic: pseudo-random cycles
    for (int i = 0; i < 4000; i++) begin
      int st, em, k, p, op, fl;
      bit iss;
      logic [31:0] r2;
      rng = nxt(rng); r2 = nxt(rng ^ 32'h9e37_79b9);
      st = (rng[2:0] == 0) ? int'(rng[4:3]) : 1;
      em = (rng[7:5] == 0) ? 1 : 0;
      k = int'(rng[10:8]) % 7;
      p = (rng[13:11] == 0) ? int'(rng[16:14]) : kpipe(k);
      op = int'(rng[18:17]);
      fl = rng[19] ? 15 : int'(rng[23:20]);
      iss = rng[24] | rng[25];
      for (int c = 0; c < 4; c++) if (m_ip[c] >= 12) iss = 0;
      cyc(st, em, k, p, op, fl, iss, r2[3:0] | r2[7:4], r2[11:8] | r2[15:12], "");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule